// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block sits between a bus master and a static memory. It passes the memory's chip-select, write-enable and output-enable strobes through while the supply is healthy. It also drives the enable for the memory's data pins and a flag that selects the backup cell. All strobes are active low. The digital supply-status flags come from comparators outside the block. `pfd` is high while the supply is under the power-fail threshold. `vso` is high while the supply is under the switchover level.

When `pfd` rises, the block opens a protect window of `PROT_CYC` cycles. During the window, a memory access that was already under way keeps its strobes until it ends, and any new access is blocked. When the window closes, protection is applied whether or not that access has finished. While the block is protected, every strobe is held inactive, the data pins are not driven, and all bus inputs are ignored. When the supply comes back, protection stays on for `RECOV_CYC` cycles before normal access resumes.

The backup cell is selected only while the supply sits under the switchover level. It is also held off from reset until the supply has been seen good at least once.

Top module: `pwr_guard`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, the outputs are `ce_n_o`=`we_n_o`=`oe_n_o`=1, `dq_oe`=0 and `bat_sel`=0. Reset leaves the block in the protected state with the backup path not yet armed.
- R2: In normal operation the three strobe outputs equal their inputs in the same cycle. `dq_oe` is 1 exactly when `ce_n_o`=0, `oe_n_o`=0 and `we_n_o`=1.
- R3: When `pfd` is sampled high at a clock edge in normal operation, the protect window starts at that edge. Protection takes effect `PROT_CYC` edges later.
- R4: Inside the window, the strobes are passed only if an access was in progress at the edge that opened the window and that same access has been continuously in progress since. An access is in progress when `ce_n_i`=0 together with `we_n_i`=0 or `oe_n_i`=0. An access that starts inside the window, or restarts after a gap, sees all strobes held at 1.
- R5: An access still in progress when the window ends loses its strobes at that edge, so it is cut off.
- R6: While the block is protected, recovering or on the backup cell, the strobes are 1 and `dq_oe` is 0, whatever the bus inputs are.
- R7: `bat_sel` rises one edge after `vso` is sampled high while protected. It falls one edge after `vso` is sampled low. `vso` takes priority over `pfd` in the protected state.
- R8: When `pfd` is sampled low while the window is open or while protected, recovery starts; normal access returns after `RECOV_CYC` edges. When `pfd` is sampled high during recovery, the block goes back to protected, and a later recovery restarts the full count.
- R9: Until `pfd` has been sampled low at least once since reset, `bat_sel` stays 0 even while `vso` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pfd | input | 1 | Supply under power-fail threshold |
| vso | input | 1 | Supply under switchover level |
| ce_n_i | input | 1 | Chip select from master, active low |
| we_n_i | input | 1 | Write enable from master, active low |
| oe_n_i | input | 1 | Output enable from master, active low |
| ce_n_o | output | 1 | Gated chip select to memory |
| we_n_o | output | 1 | Gated write enable to memory |
| oe_n_o | output | 1 | Gated output enable to memory |
| dq_oe | output | 1 | Drive enable for memory data pins |
| bat_sel | output | 1 | Backup cell selected |

## Verification
Strobe gating and `dq_oe` are combinational, so they respond to the bus inputs in the same cycle. Every change driven by `pfd` or `vso` shows up one edge after the flag is sampled. Window expiry lands exactly `PROT_CYC` edges after the window opens, and the return to normal lands `RECOV_CYC` edges after recovery starts. Inputs change one time unit after each rising edge, and the behavioural model advances at the same edge. The outputs are compared with the model at every falling edge. Directed checks for the window and recovery boundaries are placed on the last cycle before each boundary and the first cycle after it.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL     = 3'd0,
        ST_PF_PENDING = 3'd1,
        ST_PROTECTED  = 3'd2,
        ST_BATTERY    = 3'd3,
        ST_RECOVERY   = 3'd4
    } guard_state_e;

    typedef struct packed {
        guard_state_e state;
        logic         hold;   // in-flight access still allowed
        logic         armed;  // supply has been good since reset
    } guard_regs_t;

endpackage

// File: rtl/pg_access_mon.sv
module pg_access_mon (
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic busy
);
    logic wr_cyc;
    logic rd_cyc;

    always_comb begin
        wr_cyc = ~ce_n & ~we_n;
        rd_cyc = ~ce_n & ~oe_n;
        busy   = wr_cyc | rd_cyc;
    end
endmodule

// File: rtl/pg_timer.sv
module pg_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        expired = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pg_out_gate.sv
module pg_out_gate (
    input  logic pass,
    input  logic ce_n_i,
    input  logic we_n_i,
    input  logic oe_n_i,
    output logic ce_n_o,
    output logic we_n_o,
    output logic oe_n_o,
    output logic dq_oe
);
    always_comb begin
        ce_n_o = pass ? ce_n_i : 1'b1;
        we_n_o = pass ? we_n_i : 1'b1;
        oe_n_o = pass ? oe_n_i : 1'b1;
        dq_oe  = ~ce_n_o & ~oe_n_o & we_n_o;
    end
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
    import pwr_guard_pkg::*;
#(
    parameter int PROT_CYC  = 128,
    parameter int RECOV_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pfd,
    input  logic vso,
    input  logic ce_n_i,
    input  logic we_n_i,
    input  logic oe_n_i,
    output logic ce_n_o,
    output logic we_n_o,
    output logic oe_n_o,
    output logic dq_oe,
    output logic bat_sel
);
    localparam int MAX_CYC = (PROT_CYC > RECOV_CYC) ? PROT_CYC : RECOV_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam logic [TMR_W-1:0] PROT_LOAD  = TMR_W'(PROT_CYC - 1);
    localparam logic [TMR_W-1:0] RECOV_LOAD = TMR_W'(RECOV_CYC - 1);

    guard_regs_t      regs_d;
    guard_regs_t      regs_q;
    guard_state_e     state_q;
    logic             busy;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             pass;

    pg_access_mon i_access_mon (
        .ce_n (ce_n_i),
        .we_n (we_n_i),
        .oe_n (oe_n_i),
        .busy (busy)
    );

    pg_timer #(.CNT_W(TMR_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        regs_d       = regs_q;
        tmr_load     = 1'b0;
        tmr_val      = PROT_LOAD;
        regs_d.armed = regs_q.armed | ~pfd;
        case (regs_q.state)
            ST_NORMAL: begin
                if (pfd) begin
                    regs_d.state = ST_PF_PENDING;
                    regs_d.hold  = busy;
                    tmr_load     = 1'b1;
                    tmr_val      = PROT_LOAD;
                end
            end
            ST_PF_PENDING: begin
                regs_d.hold = regs_q.hold & busy;
                if (!pfd) begin
                    regs_d.state = ST_RECOVERY;
                    tmr_load     = 1'b1;
                    tmr_val      = RECOV_LOAD;
                end else if (tmr_expired) begin
                    regs_d.state = ST_PROTECTED;
                end
            end
            ST_PROTECTED: begin
                if (vso) begin
                    regs_d.state = ST_BATTERY;
                end else if (!pfd) begin
                    regs_d.state = ST_RECOVERY;
                    tmr_load     = 1'b1;
                    tmr_val      = RECOV_LOAD;
                end
            end
            ST_BATTERY: begin
                if (!vso) begin
                    regs_d.state = ST_PROTECTED;
                end
            end
            ST_RECOVERY: begin
                if (pfd) begin
                    regs_d.state = ST_PROTECTED;
                end else if (tmr_expired) begin
                    regs_d.state = ST_NORMAL;
                end
            end
            default: begin
                regs_d.state = ST_PROTECTED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_PROTECTED, hold: 1'b0, armed: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_q = regs_q.state;
    assign pass    = (state_q == ST_NORMAL) |
                     ((state_q == ST_PF_PENDING) & regs_q.hold & busy);
    assign bat_sel = (state_q == ST_BATTERY) & regs_q.armed;

    pg_out_gate i_out_gate (
        .pass   (pass),
        .ce_n_i (ce_n_i),
        .we_n_i (we_n_i),
        .oe_n_i (oe_n_i),
        .ce_n_o (ce_n_o),
        .we_n_o (we_n_o),
        .oe_n_o (oe_n_o),
        .dq_oe  (dq_oe)
    );
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk
    import pwr_guard_pkg::*;
#(
    parameter int PROT_CYC = 128
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pfd,
    input logic         vso,
    input logic         ce_n_o,
    input logic         we_n_o,
    input logic         oe_n_o,
    input logic         dq_oe,
    input logic         bat_sel,
    input guard_state_e state
);
    logic [31:0] pend_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_cnt <= '0;
        end else if (state == ST_PF_PENDING) begin
            pend_cnt <= pend_cnt + 1'b1;
        end else begin
            pend_cnt <= '0;
        end
    end

    AST_QUIET_WHEN_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_PROTECTED, ST_BATTERY, ST_RECOVERY}) |->
            (ce_n_o && we_n_o && oe_n_o && !dq_oe)); // R6

    AST_PFD_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && pfd) |=> (state == ST_PF_PENDING)); // R3

    AST_WINDOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PF_PENDING) |-> (pend_cnt < PROT_CYC)); // R5

    AST_NO_FRESH_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PF_PENDING && $past(state) == ST_PF_PENDING && $past(ce_n_o))
            |-> ce_n_o); // R4

    AST_BAT_NEEDS_VSO: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel |-> $past(vso)); // R7

    AST_RECOV_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVERY && pfd) |=> (state == ST_PROTECTED)); // R8
endmodule

bind pwr_guard pwr_guard_chk #(.PROT_CYC(PROT_CYC)) i_pwr_guard_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pfd     (pfd),
    .vso     (vso),
    .ce_n_o  (ce_n_o),
    .we_n_o  (we_n_o),
    .oe_n_o  (oe_n_o),
    .dq_oe   (dq_oe),
    .bat_sel (bat_sel),
    .state   (state_q)
);

// File: tb/test_pwr_guard.sv
`timescale 1ns/1ps
module test_pwr_guard;
    localparam int P = 8;
    localparam int R = 20;

    logic clk = 1'b0;
    logic rst_n, pfd, vso, ce_n_i, we_n_i, oe_n_i;
    logic ce_n_o, we_n_o, oe_n_o, dq_oe, bat_sel;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    pwr_guard #(.PROT_CYC(P), .RECOV_CYC(R)) i_pwr_guard (
        .clk(clk), .rst_n(rst_n), .pfd(pfd), .vso(vso),
        .ce_n_i(ce_n_i), .we_n_i(we_n_i), .oe_n_i(oe_n_i),
        .ce_n_o(ce_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o),
        .dq_oe(dq_oe), .bat_sel(bat_sel)
    );

    // behavioural model: 0 run, 1 window, 2 guarded, 3 backup, 4 recovering
    int m_mode  = 2;
    int m_count = 0;
    bit m_keep  = 0;
    bit m_armed = 0;

    function automatic bit bus_active();
        return (!ce_n_i && !we_n_i) || (!ce_n_i && !oe_n_i);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 2; m_count = 0; m_keep = 0; m_armed = 0;
        end else begin
            if (!pfd) m_armed = 1;
            case (m_mode)
                0: if (pfd) begin m_mode = 1; m_count = 0; m_keep = bus_active(); end
                1: begin
                    m_keep  = m_keep && bus_active();
                    m_count = m_count + 1;
                    if (!pfd) begin m_mode = 4; m_count = 0; end
                    else if (m_count == P) m_mode = 2;
                end
                2: if (vso) m_mode = 3;
                   else if (!pfd) begin m_mode = 4; m_count = 0; end
                3: if (!vso) m_mode = 2;
                default: begin
                    m_count = m_count + 1;
                    if (pfd) m_mode = 2;
                    else if (m_count == R) m_mode = 0;
                end
            endcase
        end
    end

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] outs();
        return {ce_n_o, we_n_o, oe_n_o, dq_oe, bat_sel};
    endfunction

    always @(negedge clk) begin
        logic [4:0] exp;
        string tag;
        bit open;
        open = (rst_n && m_mode == 0) || (rst_n && m_mode == 1 && m_keep && bus_active());
        if (open) exp = {ce_n_i, we_n_i, oe_n_i, (!ce_n_i && !oe_n_i && we_n_i), 1'b0};
        else      exp = {4'b1110, (rst_n && m_mode == 3 && m_armed)};
        if (!rst_n) tag = "R1";
        else case (m_mode)
            0: tag = "R2";
            1: tag = "R4";
            2: tag = "R6";
            3: tag = m_armed ? "R7" : "R9";
            default: tag = "R8";
        endcase
        check(tag, outs(), exp);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 5000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus(logic c, logic w, logic o);
        ce_n_i = c; we_n_i = w; oe_n_i = o;
    endtask

    initial begin
        rst_n = 0; pfd = 1; vso = 1; bus(1, 1, 1);
        repeat (3) tick();
        check("R1 reset", outs(), 5'b11100);
        rst_n = 1;
        tick(); #1;
        check("R9 unarmed backup", {4'b0, bat_sel}, 5'b0);
        repeat (2) tick();
        vso = 0; tick();
        pfd = 0; bus(0, 1, 0);
        tick();
        repeat (R - 1) tick(); #1;
        check("R8 still recovering", {ce_n_o, 4'b0}, {1'b1, 4'b0});
        tick(); #1;
        check("R8 R2 normal after recovery", {ce_n_o, dq_oe, 3'b0}, {2'b01, 3'b0});
        for (int i = 0; i < 16; i++) begin
            bus(i[0], i[1], i[2]);
            tick();
        end
        // write in flight when the window opens
        bus(0, 0, 1); pfd = 1;
        tick();
        repeat (P - 1) tick(); #1;
        check("R5 held write before window end", {we_n_o, 4'b0}, 5'b0);
        tick(); #1;
        check("R3 R5 cut at window end", {we_n_o, 4'b0}, {1'b1, 4'b0});
        for (int i = 0; i < 6; i++) begin
            bus(i[0], i[1], 1'b0);
            tick();
        end
        // recovery interrupted by pfd
        pfd = 0; bus(1, 1, 1);
        tick();
        repeat (5) tick();
        pfd = 1; tick();
        pfd = 0; tick();
        repeat (R - 1) tick(); #1;
        check("R8 full recount", {ce_n_o, 4'b0}, {1'b1, 4'b0});
        bus(0, 1, 0);
        tick(); #1;
        check("R8 normal again", {ce_n_o, 4'b0}, 5'b0);
        // idle window, new read blocked, then pfd clears
        bus(1, 1, 1); pfd = 1;
        tick();
        bus(0, 1, 0);
        tick(); #1;
        check("R4 new access blocked", {ce_n_o, dq_oe, 3'b0}, {2'b10, 3'b0});
        pfd = 0;
        tick(); #1;
        check("R8 window to recovery", outs(), 5'b11100);
        bus(1, 1, 1);
        repeat (R) tick();
        // access ends inside window and restarts
        bus(0, 0, 1); pfd = 1;
        tick();
        tick(); #1;
        check("R4 in-flight write passes", {we_n_o, 4'b0}, 5'b0);
        bus(1, 1, 1);
        tick();
        bus(0, 0, 1);
        tick(); #1;
        check("R4 restarted write blocked", {we_n_o, 4'b0}, {1'b1, 4'b0});
        repeat (P) tick();
        vso = 1;
        tick(); #1;
        check("R7 backup selected", {4'b0, bat_sel}, 5'b1);
        for (int i = 0; i < 4; i++) begin
            bus(i[0], 1'b0, i[1]);
            tick();
        end
        vso = 0;
        tick(); #1;
        check("R7 backup released", {4'b0, bat_sel}, 5'b0);
        pfd = 0; bus(1, 1, 1);
        tick();
        repeat (R + 3) tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule